// File: doc/BRIEF.md
# Adder-Subtractor with Signed-Magnitude Result

This combinational block adds or subtracts two equal-width operands and presents the outcome as a sign bit, a magnitude and an overflow flag. A format input tells the block how to read the operands. They are either plain binary counts or two's-complement numbers.

Internally the block runs one ripple-carry adder with a conditional inversion of the second operand. The adder gives a raw result: the end carry plus the sum bits. A control unit decodes the operation and the format into a few strobes. The datapath then uses those strobes to pick how the raw result is read:

- whether the result is negative,
- whether its magnitude has to be negated back to a positive count,
- whether the true value falls outside what a sign plus a `WIDTH`-bit magnitude can hold.

The default width is 4, which gives a 5-bit signed-magnitude output covering -15 to +15.

Top module: `addSubSignMag`

## Requirements
- R1: With `opSub`=0 the block evaluates opA+opB; with `opSub`=1 it evaluates opA-opB.
- R2: With `fmtSigned`=0 each operand is an unsigned count from 0 to 2^WIDTH-1 (0..15 at the default width). With `fmtSigned`=1 each operand is two's complement, from -2^(WIDTH-1) to 2^(WIDTH-1)-1 (-8..+7).
- R3: When `ovf`=0, `signOut` is 1 exactly when the true result is negative, and `magOut` is its absolute value as an unsigned binary number.
- R4: `ovf`=1 exactly when the true result lies outside -(2^WIDTH-1)..+(2^WIDTH-1); `signOut` and `magOut` are then unspecified.
- R5: An unsigned addition overflows exactly when the sum exceeds 2^WIDTH-1 (16..30 at the default width). It never reports a negative result.
- R6: An unsigned subtraction never overflows. When opA<opB it gives `signOut`=1 and `magOut`=opB-opA.
- R7: In two's-complement mode, the only result that overflows is -2^WIDTH (most negative plus most negative). Every subtraction, including those reaching +2^WIDTH-1 or -(2^WIDTH-1), is representable.
- R8: A zero result is always reported as `signOut`=0, `magOut`=0. It is never reported as negative zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSub | input | 1 | 0 = add, 1 = subtract opB from opA |
| fmtSigned | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| ovf | output | 1 | Result cannot be shown as sign plus WIDTH-bit magnitude |
| signOut | output | 1 | 1 = result is negative |
| magOut | output | WIDTH | Absolute value of the result |

## Verification
The bench builds the block at its default width of 4, where the whole input space is 1024 combinations: both formats, both operations and every operand pair. It therefore sweeps all of them and compares each against integer arithmetic. This covers every edge case:

- the full unsigned overflow band 16..30,
- the single -16 overflow in two's-complement addition,
- the ±15 extremes of two's-complement subtraction,
- each way of reaching zero.

// File: rtl/addSubSignMag_pkg.sv
package addSubSignMag_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic invertB;      // complement the second operand
    logic carryIn;      // carry into the lowest stage
    logic unsignedAdd;  // end carry means overflow
    logic unsignedSub;  // missing end carry means negative
    logic signedMode;   // extended sign bit decides the sign
  } ctrlStrobes_t;

endpackage

// File: rtl/smRippleAdder.sv
module smRippleAdder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign cout = carry[WIDTH];
endmodule

// File: rtl/smNegate.sv
module smNegate #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] negated
);
  // Two's complement: invert, then ripple-increment
  logic [WIDTH:0] incCarry;

  assign incCarry[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign negated[i]    = ~value[i] ^ incCarry[i];
    assign incCarry[i+1] = ~value[i] & incCarry[i];
  end
endmodule

// File: rtl/smControl.sv
module smControl
  import addSubSignMag_pkg::*;
(
  input  logic         opSub,
  input  logic         fmtSigned,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.invertB     = opSub;
    strobes.carryIn     = opSub;
    strobes.unsignedAdd = ~fmtSigned & ~opSub;
    strobes.unsignedSub = ~fmtSigned & opSub;
    strobes.signedMode  = fmtSigned;
  end
endmodule

// File: rtl/smDatapath.sv
module smDatapath
  import addSubSignMag_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrlStrobes_t     strobes,
  output logic             ovf,
  output logic             signOut,
  output logic [WIDTH-1:0] magOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bSel;
  logic [WIDTH-1:0] rawSum;
  logic             rawCarry;
  logic             extSign;
  logic             isNegative;
  logic [WIDTH-1:0] negSum;

  assign bSel = opB ^ {WIDTH{strobes.invertB}};

  smRippleAdder #(.WIDTH(WIDTH)) u_adder (
    .x   (opA),
    .y   (bSel),
    .cin (strobes.carryIn),
    .sum (rawSum),
    .cout(rawCarry)
  );

  // Bit WIDTH of the sign-extended sum
  assign extSign = opA[MSB] ^ bSel[MSB] ^ rawCarry;

  always_comb begin
    if (strobes.unsignedSub) begin
      isNegative = ~rawCarry;
    end else if (strobes.signedMode) begin
      isNegative = extSign;
    end else begin
      isNegative = 1'b0;
    end
  end

  always_comb begin
    if (strobes.unsignedAdd) begin
      ovf = rawCarry;
    end else if (strobes.signedMode) begin
      ovf = extSign & ~|rawSum;   // exactly -2^WIDTH
    end else begin
      ovf = 1'b0;
    end
  end

  smNegate #(.WIDTH(WIDTH)) u_neg (
    .value  (rawSum),
    .negated(negSum)
  );

  assign signOut = isNegative;
  assign magOut  = isNegative ? negSum : rawSum;
endmodule

// File: rtl/addSubSignMag.sv
module addSubSignMag
  import addSubSignMag_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             opSub,
  input  logic             fmtSigned,
  output logic             ovf,
  output logic             signOut,
  output logic [WIDTH-1:0] magOut
);
  ctrlStrobes_t strobes;

  smControl u_ctrl (
    .opSub    (opSub),
    .fmtSigned(fmtSigned),
    .strobes  (strobes)
  );

  smDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .ovf    (ovf),
    .signOut(signOut),
    .magOut (magOut)
  );
endmodule

// File: rtl/addSubSignMagChecker.sv
module addSubSignMagChecker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             opSub,
  input logic             fmtSigned,
  input logic             ovf,
  input logic             signOut,
  input logic [WIDTH-1:0] magOut
);
  localparam int LIMIT = (1 << WIDTH) - 1;

  int aVal;
  int bVal;
  int refVal;
  int shownVal;

  always_comb begin
    if (fmtSigned) begin
      aVal = int'($signed(opA));
      bVal = int'($signed(opB));
    end else begin
      aVal = int'({1'b0, opA});
      bVal = int'({1'b0, opB});
    end
    refVal   = opSub ? (aVal - bVal) : (aVal + bVal);
    shownVal = signOut ? -int'({1'b0, magOut}) : int'({1'b0, magOut});
  end

  always_comb begin
    assert_overflow_range_R4 : assert (ovf == ((refVal > LIMIT) || (refVal < -LIMIT)))
      else $error("overflow flag disagrees with result range");
    if (!ovf) begin
      assert_value_shown_R3 : assert (shownVal == refVal)
        else $error("sign/magnitude does not encode the result");
      if (magOut == '0) begin
        assert_zero_positive_R8 : assert (!signOut)
          else $error("negative zero reported");
      end
    end
    if (!fmtSigned && opSub) begin
      assert_unsigned_sub_no_ovf_R6 : assert (!ovf)
        else $error("unsigned subtraction overflowed");
    end
    if (!fmtSigned && !opSub && !ovf) begin
      assert_unsigned_add_positive_R5 : assert (!signOut)
        else $error("unsigned addition reported negative");
    end
    if (fmtSigned && opSub) begin
      assert_signed_sub_no_ovf_R7 : assert (!ovf)
        else $error("two's-complement subtraction overflowed");
    end
  end
endmodule

bind addSubSignMag addSubSignMagChecker #(.WIDTH(WIDTH)) u_checker (.*);

// File: tb/tb_addSubSignMag.sv
module tb_addSubSignMag;
  localparam int WIDTH = 4;
  localparam int SPAN  = 1 << WIDTH;
  localparam int LIMIT = SPAN - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic             opSub = 1'b0;
  logic             fmtSigned = 1'b0;
  logic             ovf;
  logic             signOut;
  logic [WIDTH-1:0] magOut;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  addSubSignMag #(.WIDTH(WIDTH)) dut (
    .opA(opA), .opB(opB), .opSub(opSub), .fmtSigned(fmtSigned),
    .ovf(ovf), .signOut(signOut), .magOut(magOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (fmt=%0d sub=%0d a=%0d b=%0d)",
               req, what, act, exp, fmtSigned, opSub, opA, opB);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Initial state: all-zero inputs give a positive zero (R8)
    check("R8", "ovf at zero inputs", int'(ovf), 0);
    check("R8", "sign at zero inputs", int'(signOut), 0);
    check("R8", "mag at zero inputs", int'(magOut), 0);

    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < SPAN; a++) begin
          for (int b = 0; b < SPAN; b++) begin
            int av, bv, res, expOvf;
            string ovfReq;
            string valReq;
            @(posedge clk);
            fmtSigned = f[0];
            opSub     = s[0];
            opA       = a[WIDTH-1:0];
            opB       = b[WIDTH-1:0];
            // R2: operand interpretation
            av = (f == 1 && a >= SPAN/2) ? a - SPAN : a;
            bv = (f == 1 && b >= SPAN/2) ? b - SPAN : b;
            // R1: operation
            res    = (s == 1) ? av - bv : av + bv;
            expOvf = (res > LIMIT || res < -LIMIT) ? 1 : 0;
            if (f == 0 && s == 0)      ovfReq = "R5";
            else if (f == 0)           ovfReq = "R6";
            else                       ovfReq = "R7";
            valReq = (res == 0) ? "R8" : ((f == 0 && s == 1) ? "R6" : "R3");
            @(negedge clk);
            check(ovfReq, "overflow (R4)", int'(ovf), expOvf);
            if (expOvf == 0) begin
              check(valReq, "sign (R1 R2)", int'(signOut), (res < 0) ? 1 : 0);
              check(valReq, "magnitude (R1 R2)", int'(magOut), (res < 0) ? -res : res);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule